// File: doc/BRIEF.md
# Frame-Rate Auto Exposure and Gain Controller

This block closes the brightness loop of an image sensor once per frame. At each frame-start pulse it takes the number of pixels that exceeded a white threshold during the frame just finished. It sorts that frame into one of five brightness classes. It then updates an 18-bit integration-time value and a 4-bit output-stage gain code. Small errors move exposure by 1/64 of its value and large errors move it by 1/8. When exposure runs into its upper or lower working zone, the gain moves one power-of-two step and exposure is rescaled by the same factor in that frame.

A host can stop either loop and supply values of its own. Those values are always applied at a frame boundary, never in the middle of a frame. The gain register has two roles. While automatic gain runs it is the ceiling that the loop may not pass. Otherwise it is the gain that is applied. Counting pixels and the analog gain stage lie outside this block.

The exposure word is handled as one binary number. Its upper 9 bits are the coarse part and its lower 9 bits are the fine part.

Top module: `exposure_gain_ctrl`

## Requirements
- R1: After reset: exposure = 4096, gain = 4'b0000, frame_class = 0, gain ceiling = 4'b0111 (x8). Host writes are not pending.
- R2: At a frame start the classes are decided in this priority order. T1 = thr_dark·256 and T2 = thr_bright·256. A count below T1/2 gives class 2 (underexposed). A count below T1 gives class 1 (below average). A count above 2·T2 gives class 4 (overexposed). A count above T2 gives class 3 (above average). Any other count gives class 0 (correct). The class appears on frame_class in the cycle after the pulse.
- R3: While automatic exposure is enabled, a class 0 frame leaves exposure unchanged. Classes 1 and 2 add a step to exposure, and classes 3 and 4 subtract one. The step is exposure/64 (rounded down) for classes 1 and 3 and exposure/8 for classes 2 and 4, and is never less than 1. The result is limited to the range from 64 up to the mode maximum.
- R4: The mode maximum is coarse 310 / fine 404 (159124) when mode_625 = 1. It is coarse 260 / fine 325 (133445) when mode_625 = 0.
- R5: A class 1 or 2 frame raises the gain one step and halves exposure (rounded down) in the same update when all of these hold: automatic gain is active, exposure ≥ max − max/8, and the next gain step does not exceed the ceiling. Otherwise the normal R3 step applies.
- R6: A class 3 or 4 frame lowers the gain one step and doubles exposure when automatic gain is active, exposure ≤ 80, and gain is not 4'b0000. Otherwise the normal R3 step applies.
- R7: Gain codes are 0000 = x1, 0001 = x2, 0011 = x4, 0111 = x8 and 1111 = x16. While automatic gain is active, the gain is never left above the ceiling after a frame start.
- R8: When automatic gain is inactive (auto_gain_en = 0 or auto_exp_en = 0), the gain holds its value. A host gain write is rounded down to the largest legal code that does not exceed it numerically, and is loaded into the ceiling register at the next frame start. At that same frame start it also becomes the gain, unless automatic gain is active.
- R9: With auto_exp_en = 0, exposure holds its value at frame starts and automatic gain is also inactive.
- R10: A host exposure write takes effect only at the next frame start, limited to the range 64 to the mode maximum. It replaces the loop result for that frame. Outputs do not move between the write and that frame start.
- R11: exposure, gain and frame_class change only in the cycle after a frame_start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| white_cnt | input | 17 | White-pixel count of the frame that just ended |
| thr_dark | input | 9 | Top 9 bits of the dark threshold T1 |
| thr_bright | input | 9 | Top 9 bits of the bright threshold T2 |
| mode_625 | input | 1 | 1 selects the 625-line exposure maximum, 0 the 525-line one |
| auto_exp_en | input | 1 | Enables the automatic exposure loop |
| auto_gain_en | input | 1 | Enables automatic gain (only while auto_exp_en = 1) |
| host_exp | input | 18 | Host exposure value |
| host_exp_wr | input | 1 | Strobe that captures host_exp as pending |
| host_gain | input | 4 | Host gain value (ceiling or direct gain) |
| host_gain_wr | input | 1 | Strobe that captures host_gain as pending |
| exposure | output | 18 | Integration time, coarse in bits 17:9 and fine in bits 8:0 |
| gain | output | 4 | Gain code |
| frame_class | output | 3 | Class of the last frame |

## Verification
The bound checker checks the following on every cycle:
- outputs stay steady between frame starts;
- the exposure bounds hold and the gain code is always legal;
- the ceiling is respected under automatic gain;
- exposure and gain stay frozen when their loops are off and no host value is pending;
- every automatic gain move comes paired with the matching halving or doubling of exposure.

Only the bench scenarios can show the rest, because they depend on arithmetic over thresholds and counts:
- the exact class boundaries at T1/2, T1, T2 and 2·T2;
- the fine and coarse step sizes;
- the mode-dependent maximum and near-maximum zone;
- the rounding of illegal host gain codes;
- the full climb to the x8 ceiling and the descent back to x1.

// File: rtl/exposure_gain_ctrl.sv
module exposure_gain_ctrl #(
  parameter int CNT_W     = 17,
  parameter int THR_W     = 9,
  parameter int EXP_W     = 18,
  parameter int EXP_MIN   = 64,
  parameter int EXP_RESET = 4096,
  parameter int COARSE_A  = 310,
  parameter int FINE_A    = 404,
  parameter int COARSE_B  = 260,
  parameter int FINE_B    = 325
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [CNT_W-1:0] white_cnt,
  input  logic [THR_W-1:0] thr_dark,
  input  logic [THR_W-1:0] thr_bright,
  input  logic             mode_625,
  input  logic             auto_exp_en,
  input  logic             auto_gain_en,
  input  logic [EXP_W-1:0] host_exp,
  input  logic             host_exp_wr,
  input  logic [3:0]       host_gain,
  input  logic             host_gain_wr,
  output logic [EXP_W-1:0] exposure,
  output logic [3:0]       gain,
  output logic [2:0]       frame_class
);

  localparam int FINE_W = EXP_W / 2;
  localparam int PAD    = CNT_W - THR_W;
  localparam logic [EXP_W-1:0] MAX_A    = EXP_W'((COARSE_A << FINE_W) + FINE_A);
  localparam logic [EXP_W-1:0] MAX_B    = EXP_W'((COARSE_B << FINE_W) + FINE_B);
  localparam logic [EXP_W-1:0] MAX_HI   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam logic [EXP_W-1:0] FLOOR    = EXP_W'(EXP_MIN);
  localparam logic [EXP_W-1:0] LOW_ZONE = EXP_W'(EXP_MIN + EXP_MIN / 4);
  localparam logic [3:0]       CEIL_RST = 4'b0111;

  typedef enum logic [2:0] {
    CLS_OK = 3'd0, CLS_LOW = 3'd1, CLS_DARK = 3'd2, CLS_HIGH = 3'd3, CLS_BRIGHT = 3'd4
  } cls_e;

  function automatic logic [3:0] legal_gain(input logic [3:0] v);
    if (v == 4'hF)       return 4'hF;
    else if (v >= 4'h7)  return 4'h7;
    else if (v >= 4'h3)  return 4'h3;
    else if (v >= 4'h1)  return 4'h1;
    else                 return 4'h0;
  endfunction

  logic [EXP_W-1:0] exp_q, exp_n, pend_exp;
  logic [3:0]       gain_q, gain_n, ceil_q, pend_gain;
  logic             exp_pend, gain_pend;
  cls_e             cls_q, cls_c;

  wire [CNT_W-1:0] t_dark      = {thr_dark, {PAD{1'b0}}};
  wire [CNT_W-1:0] t_dark_half = t_dark >> 1;
  wire [CNT_W:0]   t_bright    = {1'b0, thr_bright, {PAD{1'b0}}};
  wire [CNT_W:0]   t_bright_x2 = t_bright << 1;
  wire [CNT_W:0]   cnt_x       = {1'b0, white_cnt};

  always_comb begin
    if (white_cnt < t_dark_half)   cls_c = CLS_DARK;
    else if (white_cnt < t_dark)   cls_c = CLS_LOW;
    else if (cnt_x > t_bright_x2)  cls_c = CLS_BRIGHT;
    else if (cnt_x > t_bright)     cls_c = CLS_HIGH;
    else                           cls_c = CLS_OK;
  end

  wire              is_dark   = (cls_c == CLS_DARK)   || (cls_c == CLS_LOW);
  wire              is_bright = (cls_c == CLS_BRIGHT) || (cls_c == CLS_HIGH);
  wire              coarse    = (cls_c == CLS_DARK)   || (cls_c == CLS_BRIGHT);
  wire [EXP_W-1:0]  exp_max   = mode_625 ? MAX_A : MAX_B;
  wire [EXP_W-1:0]  near_max  = exp_max - (exp_max >> 3);

  wire [EXP_W-1:0]  step_raw  = coarse ? (exp_q >> 3) : (exp_q >> 6);
  wire [EXP_W-1:0]  step      = (step_raw == '0) ? EXP_W'(1) : step_raw;
  wire [EXP_W:0]    sum       = {1'b0, exp_q} + {1'b0, step};
  wire [EXP_W-1:0]  up_val    = (sum > {1'b0, exp_max}) ? exp_max : sum[EXP_W-1:0];
  wire [EXP_W-1:0]  dn_raw    = exp_q - step;
  wire [EXP_W-1:0]  dn_val    = (dn_raw < FLOOR) ? FLOOR : dn_raw;
  wire [EXP_W-1:0]  exp_load  = (pend_exp > exp_max) ? exp_max :
                                (pend_exp < FLOOR)   ? FLOOR   : pend_exp;

  wire              auto_gain_on = auto_exp_en & auto_gain_en;
  wire [3:0]        g_up    = {gain_q[2:0], 1'b1};
  wire [3:0]        g_dn    = {1'b0, gain_q[3:1]};
  wire [3:0]        ceil_nx = gain_pend ? pend_gain : ceil_q;
  wire              up_ok   = auto_gain_on && (gain_q != 4'hF) && (g_up <= ceil_q);
  wire              dn_ok   = auto_gain_on && (gain_q != 4'h0);

  always_comb begin
    exp_n  = exp_q;
    gain_n = gain_q;
    if (auto_exp_en) begin
      if (is_dark) begin
        if (exp_q >= near_max && up_ok) begin
          gain_n = g_up;
          exp_n  = exp_q >> 1;
        end else begin
          exp_n  = up_val;
        end
      end else if (is_bright) begin
        if (exp_q <= LOW_ZONE && dn_ok) begin
          gain_n = g_dn;
          exp_n  = exp_q << 1;
        end else begin
          exp_n  = dn_val;
        end
      end
    end
    if (gain_pend && !auto_gain_on) gain_n = pend_gain;
    if (auto_gain_on && gain_n > ceil_nx) gain_n = ceil_nx;
    if (exp_pend) exp_n = exp_load;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q     <= EXP_W'(EXP_RESET);
      gain_q    <= 4'h0;
      ceil_q    <= CEIL_RST;
      cls_q     <= CLS_OK;
      exp_pend  <= 1'b0;
      gain_pend <= 1'b0;
      pend_exp  <= '0;
      pend_gain <= 4'h0;
    end else begin
      if (frame_start) begin
        exp_q     <= exp_n;
        gain_q    <= gain_n;
        ceil_q    <= ceil_nx;
        cls_q     <= cls_c;
        exp_pend  <= 1'b0;
        gain_pend <= 1'b0;
      end
      if (host_exp_wr) begin
        exp_pend <= 1'b1;
        pend_exp <= host_exp;
      end
      if (host_gain_wr) begin
        gain_pend <= 1'b1;
        pend_gain <= legal_gain(host_gain);
      end
    end
  end

  assign exposure    = exp_q;
  assign gain        = gain_q;
  assign frame_class = cls_q;

endmodule

// File: rtl/exposure_gain_ctrl_chk.sv
module exposure_gain_ctrl_chk #(
  parameter int EXP_W   = 18,
  parameter int EXP_MIN = 64,
  parameter logic [EXP_W-1:0] EXP_TOP = 159124
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             auto_exp_en,
  input logic             auto_gain_en,
  input logic [EXP_W-1:0] exposure,
  input logic [3:0]       gain,
  input logic [2:0]       frame_class,
  input logic [3:0]       ceil_q,
  input logic             exp_pend,
  input logic             gain_pend
);

  p_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(exposure) && $stable(gain) && $stable(frame_class)));

  p_exp_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exposure >= EXP_W'(EXP_MIN)) && (exposure <= EXP_TOP));

  p_legal_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gain == 4'h0) || (gain == 4'h1) || (gain == 4'h3) || (gain == 4'h7) || (gain == 4'hF));

  p_under_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && auto_exp_en && auto_gain_en) |=> (gain <= ceil_q));

  p_exp_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !auto_exp_en && !exp_pend) |=> $stable(exposure));

  p_gain_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !(auto_exp_en && auto_gain_en) && !gain_pend) |=> $stable(gain));

  p_gain_pairs_exp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && auto_exp_en && auto_gain_en && !exp_pend && !gain_pend && (gain <= ceil_q))
    |=> ((gain == $past(gain)) ||
         ((gain == {$past(gain[2:0]), 1'b1}) && (exposure == ($past(exposure) >> 1))) ||
         ((gain == {1'b0, $past(gain[3:1])}) && (exposure == ($past(exposure) << 1)))));

endmodule

bind exposure_gain_ctrl exposure_gain_ctrl_chk #(
  .EXP_W(EXP_W), .EXP_MIN(EXP_MIN), .EXP_TOP(MAX_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .auto_exp_en(auto_exp_en), .auto_gain_en(auto_gain_en),
  .exposure(exposure), .gain(gain), .frame_class(frame_class),
  .ceil_q(ceil_q), .exp_pend(exp_pend), .gain_pend(gain_pend)
);

// File: tb/exposure_gain_ctrl_bench.sv
`timescale 1ns/1ps
module exposure_gain_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [16:0] white_cnt = '0;
  logic [8:0]  thr_dark = 9'd16;
  logic [8:0]  thr_bright = 9'd64;
  logic        mode_625 = 1'b1;
  logic        auto_exp_en = 1'b1;
  logic        auto_gain_en = 1'b1;
  logic [17:0] host_exp = '0;
  logic        host_exp_wr = 1'b0;
  logic [3:0]  host_gain = '0;
  logic        host_gain_wr = 1'b0;
  logic [17:0] exposure;
  logic [3:0]  gain;
  logic [2:0]  frame_class;

  int total = 0;
  int bad = 0;

  int m_exp, m_gain, m_ceil, m_cls, m_eval, m_gval;
  bit m_epend, m_gpend;
  int unsigned rng = 32'h1234_5678;

  always #4 clk = ~clk;

  exposure_gain_ctrl u_exposure_gain_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .white_cnt(white_cnt),
    .thr_dark(thr_dark), .thr_bright(thr_bright), .mode_625(mode_625),
    .auto_exp_en(auto_exp_en), .auto_gain_en(auto_gain_en),
    .host_exp(host_exp), .host_exp_wr(host_exp_wr),
    .host_gain(host_gain), .host_gain_wr(host_gain_wr),
    .exposure(exposure), .gain(gain), .frame_class(frame_class)
  );

  function automatic int unsigned next_rand();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  function automatic int round_gain(input int v);
    if (v >= 15) return 15;
    if (v >= 7)  return 7;
    if (v >= 3)  return 3;
    if (v >= 1)  return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic check_all(input string te, input string tg);
    chk(te, int'(exposure), m_exp);
    chk(tg, int'(gain), m_gain);
    chk("R2 class", int'(frame_class), m_cls);
  endtask

  task automatic model(input int cnt, output string te, output string tg);
    int t1, t2, mx, step, e, g, agon;
    t1 = int'(thr_dark) * 256;
    t2 = int'(thr_bright) * 256;
    mx = mode_625 ? 159124 : 133445;
    if (cnt < t1 / 2)      m_cls = 2;
    else if (cnt < t1)     m_cls = 1;
    else if (cnt > 2 * t2) m_cls = 4;
    else if (cnt > t2)     m_cls = 3;
    else                   m_cls = 0;
    agon = (auto_exp_en && auto_gain_en) ? 1 : 0;
    e = m_exp; g = m_gain;
    te = "R3"; tg = agon ? "R7" : "R8";
    if (auto_exp_en) begin
      step = (m_cls == 2 || m_cls == 4) ? m_exp / 8 : m_exp / 64;
      if (step == 0) step = 1;
      if (m_cls == 1 || m_cls == 2) begin
        if (m_exp >= mx - mx / 8 && agon == 1 && m_gain != 15 && ((m_gain * 2 + 1) <= m_ceil)) begin
          g = m_gain * 2 + 1; e = m_exp / 2; te = "R5"; tg = "R5";
        end else begin
          e = m_exp + step;
          if (e > mx) begin e = mx; te = "R4"; end
        end
      end else if (m_cls == 3 || m_cls == 4) begin
        if (m_exp <= 80 && agon == 1 && m_gain != 0) begin
          g = m_gain / 2; e = m_exp * 2; te = "R6"; tg = "R6";
        end else begin
          e = m_exp - step;
          if (e < 64) e = 64;
        end
      end
    end else begin
      te = "R9";
    end
    if (m_gpend) begin
      m_ceil = m_gval;
      if (agon == 0) g = m_gval;
      m_gpend = 0;
    end
    if (agon == 1 && g > m_ceil) begin g = m_ceil; tg = "R7"; end
    if (m_epend) begin
      e = (m_eval > mx) ? mx : ((m_eval < 64) ? 64 : m_eval);
      te = "R10";
      m_epend = 0;
    end
    m_exp = e; m_gain = g;
  endtask

  task automatic do_frame(input int cnt);
    string te, tg;
    white_cnt = 17'(cnt);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    model(cnt, te, tg);
    check_all(te, tg);
  endtask

  task automatic write_exp(input int v);
    host_exp = 18'(v);
    host_exp_wr = 1'b1;
    @(negedge clk);
    host_exp_wr = 1'b0;
    m_epend = 1; m_eval = v;
    check_all("R10 held", "R10 held");
  endtask

  task automatic write_gain(input int v);
    host_gain = 4'(v);
    host_gain_wr = 1'b1;
    @(negedge clk);
    host_gain_wr = 1'b0;
    m_gpend = 1; m_gval = round_gain(v);
    check_all("R10 held", "R8 held");
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seq[10];
    m_exp = 4096; m_gain = 0; m_ceil = 7; m_cls = 0; m_epend = 0; m_gpend = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 exposure", int'(exposure), 4096);
    chk("R1 gain", int'(gain), 0);
    chk("R1 class", int'(frame_class), 0);

    repeat (5) @(negedge clk);
    check_all("R11 idle", "R11 idle");

    // R2 boundaries: T1=4096, T2=16384
    seq = '{0, 2047, 2048, 4095, 4096, 16384, 16385, 32768, 32769, 131071};
    foreach (seq[i]) do_frame(seq[i]);

    // R5/R7: climb until gain sits at the x8 ceiling
    for (int i = 0; i < 140; i++) do_frame(0);
    chk("R7 ceiling x8", int'(gain), 7);
    chk("R4 max 625", int'(exposure), 159124);

    // R6: descend to x1
    for (int i = 0; i < 300; i++) do_frame(131071);
    chk("R6 gain floor", int'(gain), 0);
    chk("R3 exposure floor", int'(exposure), 64);

    // R4/R10: clamps in 525 mode
    mode_625 = 1'b0;
    write_exp(200000);
    repeat (3) @(negedge clk);
    check_all("R10 held", "R10 held");
    do_frame(10000);
    chk("R4 max 525", int'(exposure), 133445);
    write_exp(5);
    do_frame(10000);
    chk("R10 floor", int'(exposure), 64);

    // R8: manual gain, rounding
    auto_gain_en = 1'b0;
    write_gain(15);
    do_frame(0);
    chk("R8 direct x16", int'(gain), 15);
    write_gain(5);
    do_frame(0);
    chk("R8 rounded", int'(gain), 3);
    for (int i = 0; i < 40; i++) do_frame(0);

    // R9: exposure frozen
    auto_exp_en = 1'b0;
    auto_gain_en = 1'b1;
    for (int i = 0; i < 5; i++) do_frame(i * 30000);
    write_exp(50000);
    do_frame(0);
    auto_exp_en = 1'b1;
    // R7: ceiling lowered below current gain
    write_gain(1);
    do_frame(10000);

    // near-exhaustive random sweep
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = next_rand();
      if (r[2:0] == 3'd0) begin
        thr_dark = 9'(next_rand());
        thr_bright = 9'(next_rand());
      end
      if (r[9:4] == 6'd0) mode_625 = ~mode_625;
      if (r[15:10] == 6'd1) auto_exp_en = ~auto_exp_en;
      if (r[21:16] == 6'd2) auto_gain_en = ~auto_gain_en;
      if (r[27:22] == 6'd3) write_exp(int'(next_rand() % 262144));
      if (r[31:26] == 6'd4) write_gain(int'(next_rand() % 16));
      do_frame(int'(next_rand() % 131072));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule